// File: doc/BRIEF.md
# I2C Transmit Abort Detector

This block sits beside the bit-level engine of an I2C controller that can act as master or slave. Each cycle it collects event strobes from the bus engine, command-issue strobes from the processor side and the controller configuration. It decides whether the command in progress has to be abandoned. Every protocol-level reason for giving up is folded into one sticky abort interrupt. A source register records which reasons have been seen, with one bit for each reason.

When a new abort occurs, the block sends a one-cycle flush request to the transmit FIFO and another to the receive FIFO. Both requests come out on the same clock edge on which the interrupt rises. The processor acknowledges the abort by reading a clear register, and the bus register interface turns that read into a one-cycle `clr_rd` strobe. The strobe clears the interrupt and the source bits.

The detector has two pieces of internal context. One marks that a slave read request is still waiting for data. The other marks that a general-call command has been issued since the controller was last enabled. Turning the controller off clears both of them.

Top module: `i2c_abort_detect`

## Requirements
- R1: A strobe on `ev_addr_nack` sets source bit 0, and a strobe on `ev_data_nack` sets source bit 1.
- R2: A strobe on `ev_arb_lost` sets source bit 2.
- R3: A command strobe while `cfg_master_en` is 0 sets source bit 3. A write command issued while a slave read request is pending is exempt, because it is slave data and not a master command.
- R4: A command with `cmd_needs_restart` set while `cfg_restart_en` is 0 sets source bit 4. The same command with restart enabled raises no abort.
- R5: An acknowledged high-speed master code (`ev_hs_ack`) sets bit 5. An acknowledged start byte (`ev_sbyte_ack`) sets bit 6. An unacknowledged general-call address (`ev_gcall_nack`) sets bit 7.
- R6: A slave read request (`ev_rd_req`) that arrives while `tx_empty` is 0 sets bit 8. The same request with `tx_empty` at 1 raises no abort.
- R7: After a command with `cmd_gcall` set has been issued, every read command sets bit 9. This continues, even across clears, until `cfg_enable` is 0 for at least one cycle.
- R8: A read command issued while a slave read request is pending sets bit 10. A write command serves the pending request, after which reads raise no abort.
- R9: `abort_irq` is sticky. New cause bits are ORed into `abort_src`. A `clr_rd` strobe clears both. If a clear coincides with a new cause, the flag stays at 1 and `abort_src` holds only the new cause.
- R10: `tx_flush` and `rx_flush` pulse together for one cycle on each new abort. A new abort is the flag going from 0 to 1, or a new cause that coincides with a clear. Further causes that arrive while the flag is already set produce no pulse.
- R11: After reset, all outputs are 0. While `cfg_enable` is 0, events and commands are ignored.
- R12: All outputs are registered. A cause that is presented in a cycle appears at the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Controller enabled; 0 clears the internal context |
| cfg_master_en | input | 1 | Master operation allowed |
| cfg_restart_en | input | 1 | Restart conditions allowed |
| tx_empty | input | 1 | Transmit FIFO holds no data |
| cmd_valid | input | 1 | Processor issues a command this cycle |
| cmd_read | input | 1 | The command is a read (0 = write data) |
| cmd_gcall | input | 1 | The command targets the general-call address |
| cmd_needs_restart | input | 1 | The command cannot complete without a restart |
| ev_rd_req | input | 1 | Strobe: a remote master wants to read from us |
| ev_addr_nack | input | 1 | Strobe: address byte not acknowledged |
| ev_data_nack | input | 1 | Strobe: data byte not acknowledged |
| ev_arb_lost | input | 1 | Strobe: arbitration lost |
| ev_hs_ack | input | 1 | Strobe: high-speed master code acknowledged |
| ev_sbyte_ack | input | 1 | Strobe: start byte acknowledged |
| ev_gcall_nack | input | 1 | Strobe: general-call address not acknowledged |
| clr_rd | input | 1 | Strobe: processor read of the clear register |
| abort_irq | output | 1 | Sticky abort interrupt |
| abort_src | output | SRC_W | Accumulated cause bits |
| tx_flush | output | 1 | One-cycle transmit FIFO flush request |
| rx_flush | output | 1 | One-cycle receive FIFO flush request |

## Verification
The assertions rely on two properties of the inputs: every `ev_*` input and `clr_rd` is a single-cycle strobe, and the command fields are meaningful only while `cmd_valid` is 1. The stimulus drives each strobe for exactly one cycle and then returns it to 0. Between table vectors it turns `cfg_enable` off for a cycle, so the pending read request and the general-call context start each vector from a clean state. The directed tests then build up that context on purpose, using a read request followed by a read, a general-call followed by a read, and a clear that coincides with a new cause.

// File: rtl/i2c_abort_pkg.sv
package i2c_abort_pkg;
  // Bit position of each cause inside the source register.
  localparam int unsigned C_ADDR_NACK   = 0;
  localparam int unsigned C_DATA_NACK   = 1;
  localparam int unsigned C_ARB_LOST    = 2;
  localparam int unsigned C_SLAVE_ONLY  = 3;
  localparam int unsigned C_NO_RESTART  = 4;
  localparam int unsigned C_HS_ACK      = 5;
  localparam int unsigned C_SBYTE_ACK   = 6;
  localparam int unsigned C_GCALL_NACK  = 7;
  localparam int unsigned C_RDREQ_TXPND = 8;
  localparam int unsigned C_GCALL_READ  = 9;
  localparam int unsigned C_RD_EARLY    = 10;
  localparam int unsigned NUM_CAUSES    = 11;

  typedef struct packed {
    logic addr_nack;
    logic data_nack;
    logic arb_lost;
    logic hs_ack;
    logic sbyte_ack;
    logic gcall_nack;
    logic rd_req;
  } bus_ev_t;

  typedef struct packed {
    logic valid;
    logic rd;
    logic gcall;
    logic needs_restart;
  } cmd_t;
endpackage

// File: rtl/abort_ctx_track.sv
module abort_ctx_track (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rd_req_ev,
  input  logic serve_wr,
  input  logic gcall_cmd,
  output logic rd_pend,
  output logic gc_seen
);

  // A pending slave read request is served by a data write.
  // A new request in the same cycle wins over the write.
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      rd_pend <= 1'b0;
    end else if (rd_req_ev) begin
      rd_pend <= 1'b1;
    end else if (serve_wr) begin
      rd_pend <= 1'b0;
    end
  end

  // The general-call context only clears when the controller is disabled.
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      gc_seen <= 1'b0;
    end else if (gcall_cmd) begin
      gc_seen <= 1'b1;
    end
  end

  AST_CTX_CLEARED: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!rd_pend && !gc_seen)) else $error("context survived disable"); // R7

  AST_GC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (gc_seen && enable) |=> gc_seen) else $error("general-call context lost"); // R7

endmodule

// File: rtl/abort_cause_decode.sv
module abort_cause_decode
  import i2c_abort_pkg::*;
#(
  parameter int unsigned SRC_W = NUM_CAUSES
) (
  input  logic             enable,
  input  logic             master_en,
  input  logic             restart_en,
  input  logic             tx_empty,
  input  cmd_t             cmd,
  input  bus_ev_t          ev,
  input  logic             rd_pend,
  input  logic             gc_seen,
  output logic [SRC_W-1:0] hit
);

  logic rd_cmd;
  logic master_cmd;

  // A write while a read request waits is slave data, not a master command.
  always_comb begin
    rd_cmd     = cmd.valid && cmd.rd;
    master_cmd = cmd.valid && (cmd.rd || !rd_pend);
  end

  always_comb begin
    hit = '0;
    if (enable) begin
      hit[C_ADDR_NACK]   = ev.addr_nack;
      hit[C_DATA_NACK]   = ev.data_nack;
      hit[C_ARB_LOST]    = ev.arb_lost;
      hit[C_SLAVE_ONLY]  = master_cmd && !master_en;
      hit[C_NO_RESTART]  = cmd.valid && cmd.needs_restart && !restart_en;
      hit[C_HS_ACK]      = ev.hs_ack;
      hit[C_SBYTE_ACK]   = ev.sbyte_ack;
      hit[C_GCALL_NACK]  = ev.gcall_nack;
      hit[C_RDREQ_TXPND] = ev.rd_req && !tx_empty;
      hit[C_GCALL_READ]  = rd_cmd && gc_seen;
      hit[C_RD_EARLY]    = rd_cmd && rd_pend;
    end
  end

  AST_DISABLED_QUIET: assert final (enable || hit == '0); // R11

endmodule

// File: rtl/abort_flag_reg.sv
module abort_flag_reg #(
  parameter int unsigned SRC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] hit,
  input  logic             clr,
  output logic             abort_irq,
  output logic [SRC_W-1:0] abort_src,
  output logic             tx_flush,
  output logic             rx_flush
);

  logic any_hit;
  logic new_abort;

  always_comb begin
    any_hit   = |hit;
    new_abort = any_hit && (!abort_irq || clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_irq <= 1'b0;
    end else begin
      abort_irq <= (abort_irq && !clr) || any_hit;
    end
  end

  // One register per cause bit; a clear keeps only the causes of this cycle.
  for (genvar g = 0; g < SRC_W; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        abort_src[g] <= 1'b0;
      end else begin
        abort_src[g] <= (abort_src[g] && !clr) || hit[g];
      end
    end
  end

  // Separate registers so each FIFO gets a short, local flush net.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flush <= 1'b0;
      rx_flush <= 1'b0;
    end else begin
      tx_flush <= new_abort;
      rx_flush <= new_abort;
    end
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (abort_irq && !clr) |=> abort_irq) else $error("flag dropped"); // R9

  AST_SRC_MONO: assert property (@(posedge clk) disable iff (rst)
    (abort_irq && !clr) |=> ((abort_src & $past(abort_src)) == $past(abort_src)))
    else $error("source bit lost"); // R9

  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr && !any_hit) |=> (!abort_irq && abort_src == '0)) else $error("clear failed"); // R9

  AST_FLUSH_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_irq) |-> (tx_flush && rx_flush)) else $error("no flush on rise"); // R10

  AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (rst)
    tx_flush == rx_flush) else $error("flush split"); // R10

  AST_FLUSH_FLAG: assert property (@(posedge clk) disable iff (rst)
    tx_flush |-> abort_irq) else $error("flush without flag"); // R10

  AST_NO_REPULSE: assert property (@(posedge clk) disable iff (rst)
    (abort_irq && !clr) |=> !tx_flush) else $error("flush while set"); // R10

endmodule

// File: rtl/i2c_abort_detect.sv
module i2c_abort_detect
  import i2c_abort_pkg::*;
#(
  parameter int unsigned SRC_W = NUM_CAUSES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_master_en,
  input  logic             cfg_restart_en,
  input  logic             tx_empty,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic             cmd_gcall,
  input  logic             cmd_needs_restart,
  input  logic             ev_rd_req,
  input  logic             ev_addr_nack,
  input  logic             ev_data_nack,
  input  logic             ev_arb_lost,
  input  logic             ev_hs_ack,
  input  logic             ev_sbyte_ack,
  input  logic             ev_gcall_nack,
  input  logic             clr_rd,
  output logic             abort_irq,
  output logic [SRC_W-1:0] abort_src,
  output logic             tx_flush,
  output logic             rx_flush
);

  cmd_t             cmd;
  bus_ev_t          ev;
  logic             rd_pend;
  logic             gc_seen;
  logic [SRC_W-1:0] hit;

  always_comb begin
    cmd.valid         = cmd_valid;
    cmd.rd            = cmd_read;
    cmd.gcall         = cmd_gcall;
    cmd.needs_restart = cmd_needs_restart;
    ev.addr_nack      = ev_addr_nack;
    ev.data_nack      = ev_data_nack;
    ev.arb_lost       = ev_arb_lost;
    ev.hs_ack         = ev_hs_ack;
    ev.sbyte_ack      = ev_sbyte_ack;
    ev.gcall_nack     = ev_gcall_nack;
    ev.rd_req         = ev_rd_req;
  end

  abort_ctx_track u_ctx (
    .clk       (clk),
    .rst       (rst),
    .enable    (cfg_enable),
    .rd_req_ev (ev_rd_req),
    .serve_wr  (cmd_valid && !cmd_read),
    .gcall_cmd (cmd_valid && cmd_gcall),
    .rd_pend   (rd_pend),
    .gc_seen   (gc_seen)
  );

  abort_cause_decode #(.SRC_W(SRC_W)) u_dec (
    .enable     (cfg_enable),
    .master_en  (cfg_master_en),
    .restart_en (cfg_restart_en),
    .tx_empty   (tx_empty),
    .cmd        (cmd),
    .ev         (ev),
    .rd_pend    (rd_pend),
    .gc_seen    (gc_seen),
    .hit        (hit)
  );

  abort_flag_reg #(.SRC_W(SRC_W)) u_flag (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .clr       (clr_rd),
    .abort_irq (abort_irq),
    .abort_src (abort_src),
    .tx_flush  (tx_flush),
    .rx_flush  (rx_flush)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!abort_irq && abort_src == '0 && !tx_flush)) else $error("reset state"); // R11

endmodule

// File: tb/i2c_abort_detect_tb_top.sv
module i2c_abort_detect_tb_top;
  localparam int W = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en, mst, rse, txe, cv, crd, cgc, cnr;
  logic rq, an, dn, al, hs, sb, gn, clr;
  logic irq, txf, rxf;
  logic [W-1:0] src;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  i2c_abort_detect dut_i (
    .clk(clk), .rst(rst), .cfg_enable(en), .cfg_master_en(mst),
    .cfg_restart_en(rse), .tx_empty(txe), .cmd_valid(cv), .cmd_read(crd),
    .cmd_gcall(cgc), .cmd_needs_restart(cnr), .ev_rd_req(rq),
    .ev_addr_nack(an), .ev_data_nack(dn), .ev_arb_lost(al), .ev_hs_ack(hs),
    .ev_sbyte_ack(sb), .ev_gcall_nack(gn), .clr_rd(clr),
    .abort_irq(irq), .abort_src(src), .tx_flush(txf), .rx_flush(rxf)
  );

  // Stimulus bit positions
  localparam logic [15:0] S_EN = 16'h8000, S_MST = 16'h4000, S_RST = 16'h2000,
    S_TXE = 16'h1000, S_CV = 16'h0800, S_RD = 16'h0400, S_GC = 16'h0200,
    S_NR = 16'h0100, S_RQ = 16'h0080, S_AN = 16'h0040, S_DN = 16'h0020,
    S_AL = 16'h0010, S_HS = 16'h0008, S_SB = 16'h0004, S_GN = 16'h0002,
    S_CLR = 16'h0001;
  localparam logic [15:0] BASE = S_EN | S_MST | S_RST | S_TXE;

  // {stimulus, expected source}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {BASE | S_AN,                          11'h001},  // R1
    {BASE | S_DN,                          11'h002},  // R1
    {BASE | S_AL,                          11'h004},  // R2
    {S_EN | S_RST | S_TXE | S_CV,          11'h008},  // R3
    {S_EN | S_MST | S_TXE | S_CV | S_NR,   11'h010},  // R4
    {BASE | S_HS,                          11'h020},  // R5
    {BASE | S_SB,                          11'h040},  // R5
    {BASE | S_GN,                          11'h080},  // R5
    {S_EN | S_MST | S_RST | S_RQ,          11'h100},  // R6
    {BASE | S_CV | S_NR,                   11'h000},  // R4
    {BASE | S_CV | S_RD,                   11'h000},  // R8 idle read
    {S_MST | S_RST | S_TXE | S_AN | S_CV,  11'h000},  // R11 disabled
    {BASE | S_RQ,                          11'h000},  // R6 empty fifo
    {BASE | S_AN | S_AL,                   11'h005}   // R1 R2
  };

  task automatic apply(input logic [15:0] s);
    @(negedge clk);
    {en, mst, rse, txe, cv, crd, cgc, cnr, rq, an, dn, al, hs, sb, gn, clr} = s;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic ei, input logic [W-1:0] es,
                     input logic ef);
    checks++;
    if (irq !== ei || src !== es || txf !== ef || rxf !== ef) begin
      errors++;
      $display("FAIL %s: irq=%0b src=%03h flush=%0b/%0b expected irq=%0b src=%03h flush=%0b",
               req, irq, src, txf, rxf, ei, es, ef);
    end
  endtask

  task automatic scrub();
    apply(BASE | S_CLR);
    apply(S_MST | S_RST | S_TXE);
    apply(BASE);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {en, mst, rse, txe, cv, crd, cgc, cnr, rq, an, dn, al, hs, sb, gn, clr} = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset", 1'b0, '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    apply(BASE);
    chk("R11 idle", 1'b0, '0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][26:11]);
      chk($sformatf("R12 vector %0d", i), |VEC[i][10:0], VEC[i][10:0], |VEC[i][10:0]);
      apply(BASE);
      chk($sformatf("R10 vector %0d hold", i), |VEC[i][10:0], VEC[i][10:0], 1'b0);
      scrub();
      chk("R9 cleared", 1'b0, '0, 1'b0);
    end

    // R8: read before read request served
    apply(BASE | S_RQ);
    chk("R8 request alone", 1'b0, '0, 1'b0);
    apply(BASE | S_CV | S_RD);
    chk("R8 early read", 1'b1, 11'h400, 1'b1);
    scrub();
    apply(BASE | S_RQ);
    apply(BASE | S_CV);
    chk("R8 served write", 1'b0, '0, 1'b0);
    apply(BASE | S_CV | S_RD);
    chk("R8 read after serve", 1'b0, '0, 1'b0);
    scrub();

    // R3: slave-only controller answering a read request with data
    apply(S_EN | S_RST | S_TXE | S_RQ);
    apply(S_EN | S_RST | S_TXE | S_CV);
    chk("R3 slave data write", 1'b0, '0, 1'b0);
    scrub();

    // R7: reads after a general call abort until disable
    apply(BASE | S_CV | S_GC);
    chk("R7 gcall write", 1'b0, '0, 1'b0);
    apply(BASE | S_CV | S_RD);
    chk("R7 read after gcall", 1'b1, 11'h200, 1'b1);
    apply(BASE | S_CLR);
    apply(BASE | S_CV | S_RD);
    chk("R7 persists after clear", 1'b1, 11'h200, 1'b1);
    scrub();
    apply(BASE | S_CV | S_RD);
    chk("R7 disable restores", 1'b0, '0, 1'b0);

    // R9/R10: accumulate without a second pulse
    apply(BASE | S_AN);
    chk("R10 first cause", 1'b1, 11'h001, 1'b1);
    apply(BASE | S_DN);
    chk("R9 or-in, R10 no pulse", 1'b1, 11'h003, 1'b0);
    apply(BASE | S_CLR | S_AL);
    chk("R9 clear with new cause", 1'b1, 11'h004, 1'b1);
    apply(BASE);
    chk("R10 single pulse", 1'b1, 11'h004, 1'b0);
    apply(BASE | S_CLR);
    chk("R9 clear", 1'b0, '0, 1'b0);

    // R11: disabled controller ignores the read-request ordering rule
    apply(S_MST | S_RST | S_RQ);
    apply(S_MST | S_RST | S_CV | S_RD);
    chk("R11 disabled ignores", 1'b0, '0, 1'b0);

    // R11: reset in the middle of an abort
    apply(BASE | S_HS);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R11 reset clears", 1'b0, '0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule